// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Acknowledge Sequencer

This block ties two eight-input priority interrupt controllers into one sixteen-input system. The upper controller faces the processor. The lower controller reports into the upper one through cascade input 2. Each controller keeps its own pending, in-service and trigger-mode state. Each also has a rotating priority base, where the line at the base has the highest priority. Masks, vector bases and the automatic end-of-interrupt options come in as static configuration from a command decoder that sits outside this block.

A one-cycle acknowledge strobe makes the block resolve the upper controller's winner. If that winner is the cascade line, the block also resolves the lower controller's winner. It updates pending and in-service state at each level involved and registers the 8-bit vector. A missing winner at either level returns that level's line 7 as a spurious vector. A poll strobe reads one controller's winner without a vector cycle.

Top module: `pic_casc_seq`

## Requirements
- R1: After reset, all pending, in-service and trigger-mode bits are 0. `int_req`, `vec_vld` and `poll_vld` are 0, and the priority base of both controllers is 0, so line 0 is the highest priority.
- R2: For a line in edge mode (trigger bit 0), a rising input sets its pending bit one cycle later, and the bit stays set after the input falls. For a line in level mode (trigger bit 1), the pending bit follows the input with one cycle of delay.
- R3: A controller's winner is the unmasked pending line nearest the priority base, counting upward modulo 8. A `line_mask` bit of 1 stops that line from winning. A winner must rank strictly above every in-service line. `int_req` is high whenever the upper controller has a winner.
- R4: Whenever the lower controller has a winner, upper pending bit 2 is set in the next cycle. The external input `irq_in[2]` has no effect.
- R5: On the cycle after `ack_stb`, `vec_vld` is high for exactly one cycle. When the upper winner is a line other than 2, `vec_q` = {`base_m`, line}.
- R6: When the upper winner is line 2 and the lower controller has a winner, both winners are acknowledged and `vec_q` = {`base_s`, lower line}.
- R7: When the upper winner is line 2 but the lower controller has no winner, `vec_q` = {`base_s`, 7}.
- R8: With no upper winner, `vec_q` = {`base_m`, 7} and no pending or in-service bit changes.
- R9: With automatic EOI on for a controller, acknowledging one of its lines does not set an in-service bit. If rotation is also on, the priority base becomes that line + 1.
- R10: With automatic EOI off, acknowledging a line sets its in-service bit.
- R11: An acknowledge clears the line's pending bit only when the line is in edge mode. A level-mode line that is still high stays pending.
- R12: `trig_we[0]` writes the upper trigger register (`trig_mode[7:0]`) and `trig_we[1]` writes the lower one (`trig_mode[15:8]`). Only bits 0xF8 of the upper register and 0xDE of the lower register take the written value. The other bits stay 0.
- R13: A poll (`poll_sel` 0 for upper, 1 for lower) returns `poll_q` = 0x80 | line on the next cycle with `poll_vld` high, and clears that line's pending (edge mode) and in-service bits. A lower poll also clears upper line 2. With no winner the poll returns 0x00. If `ack_stb` is high in the same cycle, the poll is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request inputs; [7:0] upper, [15:8] lower |
| line_mask | input | 16 | Per-line mask, 1 = masked |
| base_m | input | 5 | Upper vector base (vector bits 7:3) |
| base_s | input | 5 | Lower vector base (vector bits 7:3) |
| auto_eoi | input | 2 | Automatic EOI enable; [0] upper, [1] lower |
| rot_aeoi | input | 2 | Rotate on automatic EOI; [0] upper, [1] lower |
| trig_we | input | 2 | Trigger-mode register write strobes |
| trig_wd | input | 8 | Trigger-mode write data |
| ack_stb | input | 1 | Processor acknowledge strobe, one cycle |
| poll_stb | input | 1 | Poll strobe, one cycle |
| poll_sel | input | 1 | Poll target: 0 upper, 1 lower |
| int_req | output | 1 | Interrupt request to the processor |
| vec_q | output | 8 | Registered vector |
| vec_vld | output | 1 | Vector valid, cycle after acknowledge |
| poll_q | output | 8 | Registered poll result |
| poll_vld | output | 1 | Poll result valid |
| pend | output | 16 | Pending bits, upper in [7:0] |
| insvc | output | 16 | In-service bits, upper in [7:0] |
| trig_mode | output | 16 | Trigger-mode registers, upper in [7:0] |

## Verification
On every cycle, the assertions check the timing of the vector strobe, the upper-level spurious vector, the lower-level vector base and the propagation of the cascade request. They also check in-service setting with and without automatic EOI, priority-base rotation, and the edge/level rule for clearing pending bits. Some behaviour needs a history of stimulus, so only the bench's scenarios can show it. That covers priority after rotation, blocking by an in-service line, a lower-level spurious acknowledge reached by masking after the cascade bit is set, poll clearing across both levels, and the fixed writable trigger bits. A behavioural reference model compares every output on every clock.

// File: rtl/pic_casc_pkg.sv
package pic_casc_pkg;
   localparam int LINES  = 8;
   localparam int IDX_W  = $clog2(LINES);
   localparam int VEC_W  = 8;
   localparam int BASE_W = VEC_W - IDX_W;

   typedef logic [LINES-1:0] lines_t;
   typedef logic [IDX_W-1:0] idx_t;

   typedef struct packed {
      logic hit;
      idx_t off;
   } rank_t;

   // Smallest offset p such that req[(p + base) mod LINES] is set.
   function automatic rank_t rank_first(input lines_t req, input idx_t base);
      rank_t r;
      idx_t  k;
      r.hit = 1'b0;
      r.off = '0;
      for (int p = LINES - 1; p >= 0; p--) begin
         k = idx_t'(p) + base;
         if (req[k]) begin
            r.hit = 1'b1;
            r.off = idx_t'(p);
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/pic_lane.sv
module pic_lane
   import pic_casc_pkg::*;
#(
   parameter lines_t TRIG_WMASK = '1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  lines_t lvl_in,
   input  lines_t pulse_in,
   input  lines_t mask_in,
   input  logic   aeoi,
   input  logic   rot,
   input  logic   trig_we,
   input  lines_t trig_wd,
   input  logic   ack_go,
   input  logic   drop_go,
   input  idx_t   drop_line,
   output logic   win_hit,
   output idx_t   win_line,
   output lines_t irr_q,
   output lines_t isr_q,
   output lines_t trig_q
);
   lines_t last_q;
   idx_t   pbase_q;
   lines_t irr_n, isr_n, ack_bit, drop_bit;
   rank_t  pend_r, svc_r;
   logic   ack_now;

   always_comb begin
      pend_r   = rank_first(irr_q & ~mask_in, pbase_q);
      svc_r    = rank_first(isr_q, pbase_q);
      win_hit  = pend_r.hit && (!svc_r.hit || (pend_r.off < svc_r.off));
      win_line = pend_r.off + pbase_q;
      ack_now  = ack_go && win_hit;
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign ack_bit[i]  = ack_now && (win_line == idx_t'(i));
      assign drop_bit[i] = drop_go && (drop_line == idx_t'(i));
      always_comb begin
         if (trig_q[i])
            irr_n[i] = lvl_in[i];
         else
            irr_n[i] = (irr_q[i] | (lvl_in[i] & ~last_q[i]) | pulse_in[i])
                       & ~(ack_bit[i] | drop_bit[i]);
         isr_n[i] = (isr_q[i] | (ack_bit[i] & ~aeoi)) & ~drop_bit[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q   <= '0;
         isr_q   <= '0;
         last_q  <= '0;
         pbase_q <= '0;
         trig_q  <= '0;
      end else begin
         irr_q  <= irr_n;
         isr_q  <= isr_n;
         last_q <= lvl_in;
         if (ack_now && aeoi && rot)
            pbase_q <= idx_t'(win_line + 1'b1);
         if (trig_we)
            trig_q <= trig_wd & TRIG_WMASK;
      end
   end

   p_aeoi_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now && aeoi) |=> !isr_q[$past(win_line)]);
   p_rot_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now && aeoi && rot) |=> (pbase_q == idx_t'($past(win_line) + 1'b1)));
   p_ack_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now && !aeoi) |=> isr_q[$past(win_line)]);
   p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now && trig_q[win_line] && lvl_in[win_line]) |=> irr_q[$past(win_line)]);
   p_edge_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_now && !trig_q[win_line]) |=> !irr_q[$past(win_line)]);
endmodule

// File: rtl/pic_casc_seq.sv
module pic_casc_seq
   import pic_casc_pkg::*;
#(
   parameter int     CASC_LINE    = 2,
   parameter lines_t M_TRIG_WMASK = 8'hF8,
   parameter lines_t S_TRIG_WMASK = 8'hDE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*LINES-1:0]  irq_in,
   input  logic [2*LINES-1:0]  line_mask,
   input  logic [BASE_W-1:0]   base_m,
   input  logic [BASE_W-1:0]   base_s,
   input  logic [1:0]          auto_eoi,
   input  logic [1:0]          rot_aeoi,
   input  logic [1:0]          trig_we,
   input  logic [LINES-1:0]    trig_wd,
   input  logic                ack_stb,
   input  logic                poll_stb,
   input  logic                poll_sel,
   output logic                int_req,
   output logic [VEC_W-1:0]    vec_q,
   output logic                vec_vld,
   output logic [VEC_W-1:0]    poll_q,
   output logic                poll_vld,
   output logic [2*LINES-1:0]  pend,
   output logic [2*LINES-1:0]  insvc,
   output logic [2*LINES-1:0]  trig_mode
);
   localparam idx_t CASC = idx_t'(CASC_LINE);
   localparam idx_t SPUR = idx_t'(LINES - 1);
   localparam int   PAD  = VEC_W - 1 - IDX_W;

   initial begin
      assert (CASC_LINE >= 0 && CASC_LINE < LINES);
      assert (M_TRIG_WMASK[CASC_LINE] == 1'b0);
      assert ((1 << IDX_W) == LINES && PAD >= 0);
   end

   logic   m_hit, s_hit;
   idx_t   m_line, s_line;
   lines_t m_irr, m_isr, m_trig, s_irr, s_isr, s_trig;
   lines_t m_lvl, m_pulse;
   logic   s_ack, pol, m_drop_go, s_drop_go;
   idx_t   m_drop_line;
   logic [VEC_W-1:0] vec_n, poll_n;

   always_comb begin
      m_lvl            = irq_in[LINES-1:0];
      m_lvl[CASC]      = 1'b0;
      m_pulse          = '0;
      m_pulse[CASC]    = s_hit;
      s_ack            = ack_stb && m_hit && (m_line == CASC);
      pol              = poll_stb && !ack_stb;
      m_drop_go        = pol && (poll_sel ? s_hit : m_hit);
      m_drop_line      = poll_sel ? CASC : m_line;
      s_drop_go        = pol && poll_sel && s_hit;
      if (!m_hit)
         vec_n = {base_m, SPUR};
      else if (m_line != CASC)
         vec_n = {base_m, m_line};
      else if (s_hit)
         vec_n = {base_s, s_line};
      else
         vec_n = {base_s, SPUR};
      if (poll_sel)
         poll_n = s_hit ? {1'b1, {PAD{1'b0}}, s_line} : '0;
      else
         poll_n = m_hit ? {1'b1, {PAD{1'b0}}, m_line} : '0;
   end

   pic_lane #(.TRIG_WMASK(M_TRIG_WMASK)) u_upper (
      .clk(clk), .rst_n(rst_n),
      .lvl_in(m_lvl), .pulse_in(m_pulse), .mask_in(line_mask[LINES-1:0]),
      .aeoi(auto_eoi[0]), .rot(rot_aeoi[0]),
      .trig_we(trig_we[0]), .trig_wd(trig_wd),
      .ack_go(ack_stb), .drop_go(m_drop_go), .drop_line(m_drop_line),
      .win_hit(m_hit), .win_line(m_line),
      .irr_q(m_irr), .isr_q(m_isr), .trig_q(m_trig)
   );

   pic_lane #(.TRIG_WMASK(S_TRIG_WMASK)) u_lower (
      .clk(clk), .rst_n(rst_n),
      .lvl_in(irq_in[2*LINES-1:LINES]), .pulse_in('0),
      .mask_in(line_mask[2*LINES-1:LINES]),
      .aeoi(auto_eoi[1]), .rot(rot_aeoi[1]),
      .trig_we(trig_we[1]), .trig_wd(trig_wd),
      .ack_go(s_ack), .drop_go(s_drop_go), .drop_line(s_line),
      .win_hit(s_hit), .win_line(s_line),
      .irr_q(s_irr), .isr_q(s_isr), .trig_q(s_trig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q    <= '0;
         vec_vld  <= 1'b0;
         poll_q   <= '0;
         poll_vld <= 1'b0;
      end else begin
         vec_vld  <= ack_stb;
         poll_vld <= pol;
         if (ack_stb) vec_q <= vec_n;
         if (pol) poll_q <= poll_n;
      end
   end

   assign int_req   = m_hit;
   assign pend      = {s_irr, m_irr};
   assign insvc     = {s_isr, m_isr};
   assign trig_mode = {s_trig, m_trig};

   p_ack_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> vec_vld);
   p_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> !vec_vld);
   p_spur_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && !int_req) |=> (vec_q == {$past(base_m), SPUR}));
   p_casc_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && m_hit && (m_line == CASC)) |=> (vec_q[VEC_W-1:IDX_W] == $past(base_s)));
   p_casc_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_hit && !ack_stb && !poll_stb) |=> pend[CASC_LINE]);
   p_poll_yield_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && poll_stb) |=> !poll_vld);
endmodule

// File: tb/pic_casc_seq_tb.sv
module pic_casc_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0, line_mask = '0;
   logic [4:0]  base_m = 5'h04, base_s = 5'h0E;
   logic [1:0]  auto_eoi = '0, rot_aeoi = '0, trig_we = '0;
   logic [7:0]  trig_wd = '0;
   logic        ack_stb = 1'b0, poll_stb = 1'b0, poll_sel = 1'b0;
   logic        int_req, vec_vld, poll_vld;
   logic [7:0]  vec_q, poll_q;
   logic [15:0] pend, insvc, trig_mode;

   int errs = 0, checks = 0, cyc_cnt = 0;

   always #5 clk = ~clk;

   pic_casc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_mask(line_mask),
      .base_m(base_m), .base_s(base_s), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
      .trig_we(trig_we), .trig_wd(trig_wd), .ack_stb(ack_stb), .poll_stb(poll_stb),
      .poll_sel(poll_sel), .int_req(int_req), .vec_q(vec_q), .vec_vld(vec_vld),
      .poll_q(poll_q), .poll_vld(poll_vld), .pend(pend), .insvc(insvc),
      .trig_mode(trig_mode)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] mi [0:1];
   logic [7:0] ms [0:1];
   logic [7:0] ml [0:1];
   logic [7:0] mt [0:1];
   int         mp [0:1];
   logic [7:0] mvec = '0, mpq = '0;
   bit         mvv = 0, mpv = 0;

   function automatic int mwin(int c, logic [7:0] msk);
      int pr = 8, cu = 8;
      for (int p = 0; p < 8; p++) begin
         if (pr == 8 && mi[c][(p + mp[c]) % 8] && !msk[(p + mp[c]) % 8]) pr = p;
         if (cu == 8 && ms[c][(p + mp[c]) % 8]) cu = p;
      end
      return (pr < cu) ? (pr + mp[c]) % 8 : -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            mi[c] = '0; ms[c] = '0; ml[c] = '0; mt[c] = '0; mp[c] = 0;
         end
         mvv = 0; mpv = 0; mvec = '0; mpq = '0;
      end else begin
         int w0, w1;
         logic [7:0] clr [0:1];
         logic [7:0] sets [0:1];
         logic [7:0] lv [0:1];
         logic [7:0] pul;
         w0 = mwin(0, line_mask[7:0]);
         w1 = mwin(1, line_mask[15:8]);
         for (int c = 0; c < 2; c++) begin clr[c] = '0; sets[c] = '0; end
         lv[0] = irq_in[7:0] & 8'hFB;
         lv[1] = irq_in[15:8];
         pul = (w1 >= 0) ? 8'h04 : 8'h00;
         mvv = ack_stb;
         mpv = poll_stb && !ack_stb;
         if (ack_stb) begin
            if (w0 < 0) mvec = {base_m, 3'd7};
            else begin
               if (auto_eoi[0]) begin if (rot_aeoi[0]) mp[0] = (w0 + 1) % 8; end
               else sets[0][w0] = 1'b1;
               if (!mt[0][w0]) clr[0][w0] = 1'b1;
               if (w0 != 2) mvec = {base_m, 3'(w0)};
               else if (w1 < 0) mvec = {base_s, 3'd7};
               else begin
                  if (auto_eoi[1]) begin if (rot_aeoi[1]) mp[1] = (w1 + 1) % 8; end
                  else sets[1][w1] = 1'b1;
                  if (!mt[1][w1]) clr[1][w1] = 1'b1;
                  mvec = {base_s, 3'(w1)};
               end
            end
         end else if (poll_stb) begin
            mpq = '0;
            if (!poll_sel && w0 >= 0) begin
               mpq = 8'h80 | 8'(w0);
               ms[0][w0] = 1'b0; clr[0][w0] = 1'b1;
            end else if (poll_sel && w1 >= 0) begin
               mpq = 8'h80 | 8'(w1);
               ms[1][w1] = 1'b0; clr[1][w1] = 1'b1;
               ms[0][2] = 1'b0; clr[0][2] = 1'b1;
            end
         end
         for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 8; i++) begin
               if (mt[c][i]) mi[c][i] = lv[c][i];
               else mi[c][i] = (mi[c][i] | (lv[c][i] & !ml[c][i]) | (c == 0 && pul[i]))
                               && !clr[c][i];
            end
            ms[c] = ms[c] | sets[c];
            ml[c] = lv[c];
            if (trig_we[c]) mt[c] = trig_wd & ((c == 0) ? 8'hF8 : 8'hDE);
         end
      end
   end

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 pend model", pend, {mi[1], mi[0]});
         chk("R10 insvc model", insvc, {ms[1], ms[0]});
         chk("R12 trig model", trig_mode, {mt[1], mt[0]});
         chk("R3 int_req model", 16'(int_req), 16'(mwin(0, line_mask[7:0]) >= 0));
         chk("R5 vec_vld model", 16'(vec_vld), 16'(mvv));
         if (mvv) chk("R5 vec_q model", 16'(vec_q), 16'(mvec));
         chk("R13 poll_vld model", 16'(poll_vld), 16'(mpv));
         if (mpv) chk("R13 poll_q model", 16'(poll_q), 16'(mpq));
      end
   end

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
         errs++;
         $display("FAIL R1 watchdog actual=%0d expected<20000", cyc_cnt);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      irq_in = '0; line_mask = '0; auto_eoi = '0; rot_aeoi = '0;
      trig_we = '0; ack_stb = 0; poll_stb = 0; poll_sel = 0;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic pulse(logic [15:0] bits);
      irq_in = irq_in | bits;
      cyc(1);
      irq_in = irq_in & ~bits;
   endtask

   task automatic ack();
      ack_stb = 1'b1; cyc(1); ack_stb = 1'b0;
   endtask

   task automatic poll(logic sel);
      poll_sel = sel; poll_stb = 1'b1; cyc(1); poll_stb = 1'b0;
   endtask

   task automatic wtrig(int c, logic [7:0] v);
      trig_wd = v; trig_we = (c == 0) ? 2'b01 : 2'b10; cyc(1); trig_we = '0;
   endtask

   initial begin
      #2;
      do_reset();
      cyc(1);
      // R1 reset state
      chk("R1 pend", pend, 16'h0);
      chk("R1 insvc", insvc, 16'h0);
      chk("R1 trig", trig_mode, 16'h0);
      chk("R1 int_req", 16'(int_req), 16'h0);
      chk("R1 vec_vld", 16'(vec_vld), 16'h0);

      // R12 writable trigger bits
      wtrig(0, 8'hFF); wtrig(1, 8'hFF);
      chk("R12 trig masks", trig_mode, 16'hDEF8);
      wtrig(0, 8'h00); wtrig(1, 8'h00);

      // R2, R3, R5, R10, R11 edge line 3
      pulse(16'h0008); cyc(1);
      chk("R2 edge held", 16'(pend[3]), 16'h1);
      chk("R3 int_req", 16'(int_req), 16'h1);
      ack();
      chk("R5 vector", 16'(vec_q), 16'h23);
      chk("R10 insvc set", 16'(insvc[3]), 16'h1);
      chk("R11 edge cleared", 16'(pend[3]), 16'h0);
      // R3 blocking by in-service line
      pulse(16'h0020); cyc(1);
      chk("R3 lower blocked", 16'(int_req), 16'h0);
      pulse(16'h0002); cyc(1);
      chk("R3 higher passes", 16'(int_req), 16'h1);

      // R3 mask
      do_reset();
      line_mask = 16'h0002;
      pulse(16'h0022); cyc(1);
      ack();
      chk("R3 masked skip", 16'(vec_q), 16'h25);

      // R4 / R6 cascade
      do_reset();
      pulse(16'h0004); cyc(1);
      chk("R4 ext line2 ignored", 16'(pend[2]), 16'h0);
      pulse(16'h0400); cyc(1);
      chk("R4 cascade request", 16'(pend[2]), 16'h1);
      ack();
      chk("R6 cascade vector", 16'(vec_q), 16'h72);
      chk("R6 both in service", insvc, 16'h0404);

      // R8 spurious upper
      do_reset();
      ack();
      chk("R8 spurious upper", 16'(vec_q), 16'h27);
      chk("R8 no state change", insvc | pend, 16'h0);

      // R7 spurious lower
      pulse(16'h0200); cyc(1);
      line_mask = 16'h0200; cyc(1);
      ack();
      chk("R7 spurious lower", 16'(vec_q), 16'h77);

      // R9 automatic EOI with rotation
      do_reset();
      auto_eoi = 2'b01; rot_aeoi = 2'b01;
      pulse(16'h0010);
      ack();
      chk("R9 aeoi vector", 16'(vec_q), 16'h24);
      chk("R9 no insvc", 16'(insvc[4]), 16'h0);
      pulse(16'h0028); cyc(1);
      ack();
      chk("R9 rotated winner", 16'(vec_q), 16'h25);

      // R11 level line stays pending
      do_reset();
      wtrig(0, 8'h08);
      irq_in = 16'h0008; cyc(2);
      ack();
      chk("R11 level vector", 16'(vec_q), 16'h23);
      chk("R11 level kept", 16'(pend[3]), 16'h1);
      irq_in = '0; cyc(2);

      // R13 poll
      do_reset();
      pulse(16'h0040); cyc(1);
      poll(1'b0);
      chk("R13 poll upper", 16'(poll_q), 16'h86);
      chk("R13 poll cleared", 16'(pend[6]), 16'h0);
      poll(1'b0);
      chk("R13 poll empty", 16'(poll_q), 16'h00);
      pulse(16'h0200); cyc(1);
      poll(1'b1);
      chk("R13 poll lower", 16'(poll_q), 16'h81);
      cyc(1);
      chk("R13 cascade cleared", pend, 16'h0);
      pulse(16'h0001);
      ack_stb = 1'b1; poll_stb = 1'b1; cyc(1); ack_stb = 1'b0; poll_stb = 1'b0;
      chk("R13 ack precedence", 16'(poll_vld), 16'h0);
      chk("R5 ack with poll", 16'(vec_q), 16'h20);
      cyc(3);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule